// File: doc/BRIEF.md
# LPI Table Base Register Unit

This block keeps the two 64-bit base registers that tell an interrupt redistributor where its LPI tables live in memory: one points at the property table, the other at the pending table. It also holds the LPI-enable control bit. Software reaches all three registers over a simple register bus that carries 32-bit or 64-bit accesses. A 32-bit write changes only one half of a base register. Every value is cleaned before it is stored: illegal shareability and cacheability encodings are remapped to legal ones, and reserved bits are forced to zero.

While LPIs are enabled, both base registers are frozen. When the enable bit turns on, the block emits a one-cycle pulse so that a table walker can start. When it turns off, the block emits a one-cycle flush pulse. If the LPI feature is configured out, the enable bit is tied to zero. The stored base values drive output ports directly, so a table walker can use them without a bus read. Reads are combinational. A read returns the chosen bytes shifted down to bit 0.

Register map (byte offsets, all parameters): control register at `CTRL_OFF` (default 0x00, bit 0 = LPI enable); property base at `PROP_OFF` (default 0x08); pending base at `PEND_OFF` (default 0x10). Any other offset reads as zero and ignores writes.

Top module: `lpi_base_regs`

## Requirements
- R1: After reset, `prop_base`, `pend_base`, `lpi_en`, `flush_pulse` and `enable_pulse` are all 0.
- R2: On the clock edge of a write, what is stored depends on the access. A write with `size64`=1 replaces all 64 bits. A 32-bit write with `addr[2]`=1 replaces only bits 63:32 with `wdata[31:0]`. A 32-bit write with `addr[2]`=0 replaces only bits 31:0 with `wdata[31:0]`. The stored value is the merged value after cleaning (R5 to R9).
- R3: `rdata` equals the selected 64-bit register shifted right by 8*`addr[2:0]` bits. With `size64`=0, bits 63:32 of `rdata` are zero. The control register reads as `lpi_en` in bit 0. Unmapped offsets read 0.
- R4: While `lpi_en`=1, writes to either base register leave it unchanged.
- R5: A shareability field (bits 11:10; 0 none, 1 inner, 2 outer) written as 2 is stored as 1. Every other value is stored as written.
- R6: An inner cacheability field (bits 9:7) written as 0 (device) or 1 (non-cacheable) is stored as 3 (read-allocate write-back). Every other value is stored as written.
- R7: An outer cacheability field (bits 58:56) is kept only if it is 0 (same as inner) or 1 (non-cacheable). Every other value is stored as 1.
- R8: In the property base register, bits 63:59, 55:52 and 6:5 always read as 0.
- R9: In the pending base register, bits 63, 61:59, 55:52, 15:12 and 6:0 always read as 0.
- R10: A write to the control register that covers its low half (`size64`=1 or `addr[2]`=0) loads `lpi_en` from `wdata[0]`. Other control writes have no effect. A 1-to-0 change raises `flush_pulse` for exactly one cycle. A 0-to-1 change raises `enable_pulse` for exactly one cycle. Both pulses appear in the same cycle as the new `lpi_en` value.
- R11: With `LPI_PRESENT`=0, `lpi_en` stays 0 and neither pulse ever rises, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| size64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 64 | Write data; 32-bit writes use bits 31:0 |
| rdata | output | 64 | Combinational read data, right-aligned |
| prop_base | output | 64 | Stored property table base |
| pend_base | output | 64 | Stored pending table base |
| lpi_en | output | 1 | LPI-enable bit |
| flush_pulse | output | 1 | One-cycle pulse on an enable 1-to-0 change |
| enable_pulse | output | 1 | One-cycle pulse on an enable 0-to-1 change |

## Verification
The assertions assume that a 64-bit access always has `addr[2]`=0. They also assume that `wr_en` is held only for the cycle of one access. Under those assumptions, they check freezing, remapping, masking and the pulse relations. The stimulus follows the same rules: it picks `addr[2]` only for 32-bit accesses, and it gives each write one strobe cycle with inputs driven on the falling clock edge. Random sequences of data, halves and control toggles are mixed with directed cases. The directed cases cover each attribute encoding, writes while frozen, and a second instance built with the LPI feature absent.

// File: rtl/lpi_base_pkg.sv
package lpi_base_pkg;
   localparam int unsigned REG_W = 64;

   localparam logic [1:0] SH_INNER = 2'd1;
   localparam logic [1:0] SH_OUTER = 2'd2;
   localparam logic [2:0] CA_DEV   = 3'd0;
   localparam logic [2:0] CA_NC    = 3'd1;
   localparam logic [2:0] CA_WB    = 3'd3;

   // reserved-zero masks
   localparam logic [REG_W-1:0] PROP_RES0 = 64'hF8F0_0000_0000_0060;
   localparam logic [REG_W-1:0] PEND_RES0 = 64'hB8F0_0000_0000_F07F;

   function automatic logic [REG_W-1:0] clean_attr(input logic [REG_W-1:0] v,
                                                   input logic [REG_W-1:0] res0);
      logic [REG_W-1:0] r;
      r = v;
      if (r[11:10] == SH_OUTER) r[11:10] = SH_INNER;
      if (r[9:7] == CA_DEV || r[9:7] == CA_NC) r[9:7] = CA_WB;
      if (!(r[58:56] == CA_DEV || r[58:56] == CA_NC)) r[58:56] = CA_NC;
      return r & ~res0;
   endfunction
endpackage

// File: rtl/lpi_base_slot.sv
module lpi_base_slot
   import lpi_base_pkg::*;
#(
   parameter bit IS_PEND = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             locked,
   input  logic             size64,
   input  logic             hi_half,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] value
);
   localparam logic [REG_W-1:0] RES0 = IS_PEND ? PEND_RES0 : PROP_RES0;
   localparam int unsigned HALF = REG_W / 2;

   logic [REG_W-1:0] merged;
   logic [REG_W-1:0] cleaned;

   always_comb begin
      if (size64)       merged = wdata;
      else if (hi_half) merged = {wdata[HALF-1:0], value[HALF-1:0]};
      else              merged = {value[REG_W-1:HALF], wdata[HALF-1:0]};
      cleaned = clean_attr(merged, RES0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              value <= '0;
      else if (hit && !locked) value <= cleaned;
   end
endmodule

// File: rtl/lpi_enable_ctl.sv
module lpi_enable_ctl #(
   parameter bit LPI_PRESENT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic new_bit,
   output logic en,
   output logic flush_p,
   output logic enable_p
);
   generate
      if (LPI_PRESENT) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en       <= 1'b0;
               flush_p  <= 1'b0;
               enable_p <= 1'b0;
            end else begin
               flush_p  <= 1'b0;
               enable_p <= 1'b0;
               if (load) begin
                  en       <= new_bit;
                  flush_p  <= en & ~new_bit;
                  enable_p <= ~en & new_bit;
               end
            end
         end
      end else begin : g_absent
         logic unused_in;
         assign unused_in = &{1'b0, clk, rst_n, load, new_bit};
         assign en       = 1'b0;
         assign flush_p  = 1'b0;
         assign enable_p = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/lpi_base_regs.sv
module lpi_base_regs
   import lpi_base_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned CTRL_OFF    = 'h00,
   parameter int unsigned PROP_OFF    = 'h08,
   parameter int unsigned PEND_OFF    = 'h10,
   parameter bit          LPI_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              size64,
   input  logic [ADDR_W-1:0] addr,
   input  logic [63:0]       wdata,
   output logic [63:0]       rdata,
   output logic [63:0]       prop_base,
   output logic [63:0]       pend_base,
   output logic              lpi_en,
   output logic              flush_pulse,
   output logic              enable_pulse
);
   localparam int unsigned WA_W = ADDR_W - 3;
   localparam int unsigned NSLOT = 2;
   localparam logic [WA_W-1:0] CTRL_WA = WA_W'(CTRL_OFF >> 3);
   localparam logic [WA_W-1:0] PROP_WA = WA_W'(PROP_OFF >> 3);
   localparam logic [WA_W-1:0] PEND_WA = WA_W'(PEND_OFF >> 3);

   generate
      if (ADDR_W < 4) begin : g_bad_aw
         $error("ADDR_W too small for three 8-byte registers");
      end
      if ((CTRL_OFF % 8) != 0 || (PROP_OFF % 8) != 0 || (PEND_OFF % 8) != 0) begin : g_bad_align
         $error("register offsets must be 8-byte aligned");
      end
      if (CTRL_OFF == PROP_OFF || CTRL_OFF == PEND_OFF || PROP_OFF == PEND_OFF) begin : g_bad_overlap
         $error("register offsets must differ");
      end
      if (PROP_OFF >= (1 << ADDR_W) || PEND_OFF >= (1 << ADDR_W) || CTRL_OFF >= (1 << ADDR_W)) begin : g_bad_range
         $error("register offset outside address space");
      end
   endgenerate

   logic [WA_W-1:0] wa;
   logic [63:0]     slot_val [NSLOT];
   logic [NSLOT-1:0] slot_hit;
   assign wa = addr[ADDR_W-1:3];
   assign slot_hit[0] = wr_en && (wa == PROP_WA);
   assign slot_hit[1] = wr_en && (wa == PEND_WA);

   genvar gi;
   generate
      for (gi = 0; gi < NSLOT; gi++) begin : g_slot
         lpi_base_slot #(.IS_PEND(gi == 1)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (slot_hit[gi]),
            .locked  (lpi_en),
            .size64  (size64),
            .hi_half (addr[2]),
            .wdata   (wdata),
            .value   (slot_val[gi])
         );
      end
   endgenerate

   assign prop_base = slot_val[0];
   assign pend_base = slot_val[1];

   logic ctrl_load;
   assign ctrl_load = wr_en && (wa == CTRL_WA) && (size64 || !addr[2]);

   lpi_enable_ctl #(.LPI_PRESENT(LPI_PRESENT)) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctrl_load),
      .new_bit  (wdata[0]),
      .en       (lpi_en),
      .flush_p  (flush_pulse),
      .enable_p (enable_pulse)
   );

   logic [63:0] sel;
   logic [63:0] shifted;
   always_comb begin
      if (wa == PROP_WA)      sel = slot_val[0];
      else if (wa == PEND_WA) sel = slot_val[1];
      else if (wa == CTRL_WA) sel = {63'd0, lpi_en};
      else                    sel = '0;
      shifted = sel >> {addr[2:0], 3'b000};
      rdata   = size64 ? shifted : {32'd0, shifted[31:0]};
   end
endmodule

// File: rtl/lpi_base_regs_chk.sv
module lpi_base_regs_chk #(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned PROP_OFF    = 'h08,
   parameter int unsigned PEND_OFF    = 'h10,
   parameter bit          LPI_PRESENT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              size64,
   input logic [ADDR_W-1:0] addr,
   input logic [63:0]       prop_base,
   input logic [63:0]       pend_base,
   input logic              lpi_en,
   input logic              flush_pulse,
   input logic              enable_pulse
);
   localparam logic [ADDR_W-4:0] P_WA = (ADDR_W-3)'(PROP_OFF >> 3);
   localparam logic [ADDR_W-4:0] Q_WA = (ADDR_W-3)'(PEND_OFF >> 3);

   logic prop_wr, pend_wr;
   assign prop_wr = wr_en && addr[ADDR_W-1:3] == P_WA;
   assign pend_wr = wr_en && addr[ADDR_W-1:3] == Q_WA;

   assert_lock_prop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prop_wr && lpi_en) |=> $stable(prop_base));
   assert_lock_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_wr && lpi_en) |=> $stable(pend_base));
   assert_low_write_keeps_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (prop_wr && !size64 && !addr[2]) |=> prop_base[63:32] == $past(prop_base[63:32]));
   assert_no_outer_share_R5: assert property (@(posedge clk) disable iff (!rst_n)
      prop_base[11:10] != 2'd2 && pend_base[11:10] != 2'd2);
   assert_inner_cache_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      prop_base[9:7] > 3'd1 || prop_base == 64'd0);
   assert_outer_cache_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_base[58:56] <= 3'd1);
   assert_prop_res0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prop_base & 64'hF8F0_0000_0000_0060) == 64'd0);
   assert_pend_res0_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_base & 64'hB8F0_0000_0000_F07F) == 64'd0);
   assert_flush_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |-> (!lpi_en && $past(lpi_en)));
   assert_enable_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      enable_pulse |-> (lpi_en && !$past(lpi_en)));
   assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_pulse || enable_pulse) |=> !(flush_pulse || enable_pulse));
   assert_absent_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !LPI_PRESENT |-> (!lpi_en && !flush_pulse && !enable_pulse));
endmodule

bind lpi_base_regs lpi_base_regs_chk #(
   .ADDR_W(ADDR_W), .PROP_OFF(PROP_OFF), .PEND_OFF(PEND_OFF), .LPI_PRESENT(LPI_PRESENT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .size64(size64), .addr(addr),
   .prop_base(prop_base), .pend_base(pend_base), .lpi_en(lpi_en),
   .flush_pulse(flush_pulse), .enable_pulse(enable_pulse)
);

// File: tb/tb_lpi_base_regs.sv
`timescale 1ns/1ps
module tb_lpi_base_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        size64 = 1'b0;
   logic [4:0]  addr = '0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata, prop_base, pend_base, rdata_o, prop_o, pend_o;
   logic        lpi_en, flush_pulse, enable_pulse, en_o, fl_o, ep_o;

   always #2.5 clk = ~clk;

   lpi_base_regs dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .size64(size64), .addr(addr),
      .wdata(wdata), .rdata(rdata), .prop_base(prop_base), .pend_base(pend_base),
      .lpi_en(lpi_en), .flush_pulse(flush_pulse), .enable_pulse(enable_pulse));

   lpi_base_regs #(.LPI_PRESENT(1'b0)) dut_off (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .size64(size64), .addr(addr),
      .wdata(wdata), .rdata(rdata_o), .prop_base(prop_o), .pend_base(pend_o),
      .lpi_en(en_o), .flush_pulse(fl_o), .enable_pulse(ep_o));

   int checks = 0;
   int errors = 0;
   logic [63:0] m_prop = '0, m_pend = '0;
   logic        m_en = 1'b0, m_fl = 1'b0, m_ep = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] fix(input logic [63:0] v, input bit pend);
      logic [63:0] r = v;
      if (r[11:10] == 2'd2) r[11:10] = 2'd1;
      if (r[9:7] <= 3'd1) r[9:7] = 3'd3;
      if (r[58:56] > 3'd1) r[58:56] = 3'd1;
      if (pend) begin
         r[63] = 0; r[61:59] = 0; r[55:52] = 0; r[15:12] = 0; r[6:0] = 0;
      end else begin
         r[63:59] = 0; r[55:52] = 0; r[6:5] = 0;
      end
      return r;
   endfunction

   function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d,
                                         input bit s64, input bit hi);
      if (s64) return d;
      if (hi) return {d[31:0], old[31:0]};
      return {old[63:32], d[31:0]};
   endfunction

   task automatic wr(input logic [4:0] a, input bit s64, input logic [63:0] d);
      @(negedge clk);
      addr = a; size64 = s64; wdata = d; wr_en = 1'b1;
      m_fl = 1'b0; m_ep = 1'b0;
      if (a[4:3] == 2'd1 && !m_en) m_prop = fix(merge(m_prop, d, s64, a[2]), 1'b0);
      if (a[4:3] == 2'd2 && !m_en) m_pend = fix(merge(m_pend, d, s64, a[2]), 1'b1);
      if (a[4:3] == 2'd0 && (s64 || !a[2])) begin
         m_fl = m_en && !d[0];
         m_ep = !m_en && d[0];
         m_en = d[0];
      end
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      chk(prop_base == m_prop, "R2/R4/R8 prop", prop_base, m_prop);
      chk(pend_base == m_pend, "R2/R4/R9 pend", pend_base, m_pend);
      chk(lpi_en == m_en && flush_pulse == m_fl && enable_pulse == m_ep, "R10 enable",
          {61'd0, lpi_en, flush_pulse, enable_pulse}, {61'd0, m_en, m_fl, m_ep});
   endtask

   task automatic rd(input logic [4:0] a, input bit s64);
      logic [63:0] sel, exp;
      @(negedge clk);
      addr = a; size64 = s64;
      #1;
      case (a[4:3])
         2'd0: sel = {63'd0, m_en};
         2'd1: sel = m_prop;
         2'd2: sel = m_pend;
         default: sel = '0;
      endcase
      exp = sel >> (8 * a[2:0]);
      if (!s64) exp[63:32] = '0;
      chk(rdata == exp, "R3 read", rdata, exp);
   endtask

   initial begin : watchdog
      #(5ns * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(prop_base == 0 && pend_base == 0, "R1 bases", prop_base | pend_base, 64'd0);
      chk(!lpi_en && !flush_pulse && !enable_pulse, "R1 ctrl",
          {61'd0, lpi_en, flush_pulse, enable_pulse}, 64'd0);

      // R5 outer shareable -> inner; R6 inner device -> WB
      wr(5'h08, 1'b0, 64'h0000_0000_0000_0800);
      chk(prop_base[11:10] == 2'd1, "R5 share", {62'd0, prop_base[11:10]}, 64'd1);
      chk(prop_base[9:7] == 3'd3, "R6 inner dev", {61'd0, prop_base[9:7]}, 64'd3);
      wr(5'h08, 1'b0, 64'h0000_0000_0000_0480);
      chk(prop_base[9:7] == 3'd3 && prop_base[11:10] == 2'd1, "R5 R6 nc",
          {52'd0, prop_base[11:0]}, 64'h580);
      wr(5'h08, 1'b0, 64'h0000_0000_0000_0300);
      chk(prop_base[9:7] == 3'd6, "R6 keep", {61'd0, prop_base[9:7]}, 64'd6);
      // R7 outer remap and keep
      wr(5'h10, 1'b0, 64'h0000_0000_0700_0000 << 32 >> 32);
      wr(5'h14, 1'b0, 64'h0000_0000_0500_0000);
      chk(pend_base[58:56] == 3'd1, "R7 remap", {61'd0, pend_base[58:56]}, 64'd1);
      wr(5'h14, 1'b0, 64'h0000_0000_0000_0000);
      chk(pend_base[58:56] == 3'd0, "R7 keep", {61'd0, pend_base[58:56]}, 64'd0);
      // R8 R9 all-ones
      wr(5'h08, 1'b1, '1);
      wr(5'h10, 1'b1, '1);
      // R10 enable, R4 lock
      wr(5'h00, 1'b0, 64'd1);
      wr(5'h08, 1'b1, 64'h0123_4567_89AB_CDEF);
      wr(5'h14, 1'b0, 64'h0);
      rd(5'h08, 1'b1);
      rd(5'h0C, 1'b0);
      rd(5'h00, 1'b0);
      wr(5'h04, 1'b0, 64'd0);   // upper-half ctrl write: no effect
      wr(5'h00, 1'b1, 64'd0);
      // R11 absent variant observed through its ports
      chk(!en_o && !fl_o && !ep_o, "R11 absent", {61'd0, en_o, fl_o, ep_o}, 64'd0);
      wr(5'h00, 1'b0, 64'd1);
      chk(!en_o && !ep_o, "R11 absent en", {62'd0, en_o, ep_o}, 64'd0);
      rd(5'h00, 1'b0);
      chk(rdata_o == 64'd0, "R11 absent read", rdata_o, 64'd0);
      wr(5'h00, 1'b0, 64'd0);

      for (int i = 0; i < 600; i++) begin
         int unsigned kind = $urandom % 8;
         bit s64 = $urandom % 2;
         logic [4:0] a = 5'(($urandom % 4) * 8);
         if (!s64) a[2] = 1'($urandom % 2);
         if (kind < 4) begin
            logic [63:0] d = {$urandom, $urandom};
            if (a[4:3] == 2'd0) d = 64'($urandom % 2);
            wr(a, s64, d);
         end else begin
            if (!s64) a[1:0] = 2'($urandom % 4);
            rd(a, s64);
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule